// File: doc/BRIEF.md
# NAND Flash Command Sequencer

This block runs one complete NAND flash operation from a single write of a control word. Software first loads an optional follow-up command byte, a transfer length and the address bytes. It then writes the control word with its start bit set. The engine then drives the flash pins through a fixed order of phases:

- a command cycle with CLE high;
- zero to eight address cycles with ALE high;
- an optional read or write data phase of the programmed length;
- an optional second command cycle;
- a settle delay, then a wait for the ready/busy line.

When the flash reports ready again, a done flag is set in the interrupt register and on the `irq` pin. Software clears the flag by writing 1 to it. Two-step operations such as program with confirm, or erase with confirm, run as one hardware sequence.

Data moves through a small byte buffer that is mapped into the register window. A write phase sends bytes from buffer index 0 upward. A read phase stores the incoming bytes there, from index 0 upward. Every flash bus cycle holds its strobe low for `CYC_LO` clocks and then high for `CYC_HI` clocks. All flash pins come straight from flops.

Top module: `nfc_cmd_engine`

## Requirements
- R1: Writing register 0 with bit 31 set while the engine is idle and not held in soft reset starts a sequence. The first bus cycle has CLE high and carries bits 7:0 on the data pins. During the sequence, chip enable `nf_ce_n[1]` is driven low if bit 19 is set, and `nf_ce_n[0]` is driven low otherwise. When the engine is idle, both chip enables are high.
- R2: If bit 30 of the control word is set, there are n = bits 29:27 + 1 address cycles (ALE high). If bit 30 is clear, there are none. Address byte k is byte k of the value {row register bits 23:0, column register bits 15:0}, lowest byte first. Bytes 5 to 7 are zero.
- R3: If bit 25 is set and bit 26 is clear, the engine runs a write data phase when the length register (2) is nonzero. It sends that many bytes on WE# strobes, with byte i taken from buffer entry i mod BUF_DEPTH. Buffer entry j sits at bus address 0x20 + j.
- R4: If bit 26 is set, the engine runs a read data phase when the length is nonzero, and bit 25 is then ignored. Each byte is sampled while RE# is low and stored at buffer entry i mod BUF_DEPTH. A length of 0 gives no data phase.
- R5: If bit 8 of register 1 is set, its bits 7:0 are sent as a second CLE cycle after the address and data phases.
- R6: After the last bus cycle, the engine waits TWB clocks before it samples ready/busy. It then waits for ready (1). After that, bit 31 of the interrupt register (6) and the `irq` pin go high.
- R7: Writing register 6 with bit 31 set clears the done flag. Writing it with bit 31 clear leaves the flag unchanged.
- R8: Status register (5) bit 30 shows the synchronised ready/busy line. Bit 31 is 1 while a sequence is running.
- R9: A start write to register 0 while a sequence is running is ignored. No extra bus cycle follows the running sequence.
- R10: While bit 0 of register 7 is 1, the engine is held idle, a running sequence is aborted and the done flag is cleared. Writing 0 to the bit lets the engine start again.
- R11: After the synchronous reset, all chip enables, WE# and RE# are high, CLE, ALE and the output enable are low, and status bit 31 and the interrupt flag read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register word index; top bit selects the buffer window |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_rdata | output | 32 | Read data, valid one clock after the address |
| irq | output | 1 | Done flag |
| nf_ce_n | output | 2 | Active-low chip enables |
| nf_cle | output | 1 | Command latch enable |
| nf_ale | output | 1 | Address latch enable |
| nf_we_n | output | 1 | Write strobe, active low |
| nf_re_n | output | 1 | Read strobe, active low |
| nf_dq_o | output | 8 | Data pins, driven value |
| nf_dq_oe | output | 1 | Data pin output enable |
| nf_dq_i | input | 8 | Data pins, sampled value |
| nf_rb | input | 1 | Ready/busy, 1 = ready |

## Verification
A phase counter or byte counter that is off by one shows at the pins within one bus cycle: the strobe count in the log of CLE, ALE and data bytes is wrong, and it is compared with the counts expected from the control word. A wrong capture cycle or a wrong buffer index during a read is not seen on the pins. It only shows when the buffer is read back over the bus after the done flag. A flaw in the done or busy logic shows as a missing or early `irq`, or as status bits that are wrong within one read.

// File: rtl/nfc_pkg.sv
package nfc_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_CMD1, S_ADDR, S_DATA, S_CMD2, S_TWB, S_WAITRDY
  } seq_state_t;

  localparam logic [2:0] RI_OP     = 3'd0;
  localparam logic [2:0] RI_FOLLOW = 3'd1;
  localparam logic [2:0] RI_LEN    = 3'd2;
  localparam logic [2:0] RI_COL    = 3'd3;
  localparam logic [2:0] RI_ROW    = 3'd4;
  localparam logic [2:0] RI_STATUS = 3'd5;
  localparam logic [2:0] RI_IRQ    = 3'd6;
  localparam logic [2:0] RI_SRST   = 3'd7;

  localparam int OP_GO    = 31;
  localparam int OP_APRES = 30;
  localparam int OP_RD    = 26;
  localparam int OP_WR    = 25;
  localparam int OP_CESEL = 19;
  localparam int FOL_EN   = 8;
  localparam int ST_BUSY  = 31;
  localparam int ST_RDY   = 30;
  localparam int IRQ_DONE = 31;
endpackage

// File: rtl/nfc_buf.sv
module nfc_buf #(
  parameter int DEPTH = 32,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [7:0]    wd,
  input  logic [AW-1:0] ra,
  output logic [7:0]    q
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
    q <= mem[ra];
  end
endmodule

// File: rtl/nfc_regs.sv
module nfc_regs
  import nfc_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int BUF_AW = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_we,
  input  logic              seq_busy,
  input  logic              seq_done,
  input  logic              rb_s,
  input  logic [7:0]        mem_q,
  output logic [31:0]       op_q,
  output logic [8:0]        follow_q,
  output logic [31:0]       len_q,
  output logic [15:0]       col_q,
  output logic [23:0]       row_q,
  output logic              go_q,
  output logic              srst_q,
  output logic              done_q,
  output logic [31:0]       bus_rdata,
  output logic              bb_we,
  output logic [BUF_AW-1:0] bb_idx,
  output logic [7:0]        bb_wd
);
  logic        win_buf;
  logic [2:0]  idx;
  logic        reg_we;
  logic        w1c;
  logic [31:0] reg_rd;
  logic [31:0] rd_q;
  logic        sel_buf_q;

  assign win_buf = bus_addr[ADDR_W-1];
  assign idx     = bus_addr[2:0];
  assign reg_we  = bus_we && !win_buf;
  assign w1c     = reg_we && (idx == RI_IRQ) && bus_wdata[IRQ_DONE];

  // Buffer writes from the bus only while the engine is idle
  assign bb_we  = bus_we && win_buf && !seq_busy;
  assign bb_idx = bus_addr[BUF_AW-1:0];
  assign bb_wd  = bus_wdata[7:0];

  always_comb begin
    reg_rd = '0;
    case (idx)
      RI_OP:     reg_rd = {1'b0, op_q[30:0]};
      RI_FOLLOW: reg_rd = {23'd0, follow_q};
      RI_LEN:    reg_rd = len_q;
      RI_COL:    reg_rd = {16'd0, col_q};
      RI_ROW:    reg_rd = {8'd0, row_q};
      RI_STATUS: begin
        reg_rd[ST_BUSY] = seq_busy;
        reg_rd[ST_RDY]  = rb_s;
      end
      RI_IRQ:    reg_rd[IRQ_DONE] = done_q;
      default:   reg_rd = {31'd0, srst_q};
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      op_q      <= '0;
      follow_q  <= '0;
      len_q     <= '0;
      col_q     <= '0;
      row_q     <= '0;
      go_q      <= 1'b0;
      srst_q    <= 1'b0;
      done_q    <= 1'b0;
      rd_q      <= '0;
      sel_buf_q <= 1'b0;
    end else begin
      go_q <= 1'b0;
      if (reg_we) begin
        case (idx)
          RI_OP: begin
            op_q <= bus_wdata;
            go_q <= bus_wdata[OP_GO];
          end
          RI_FOLLOW: follow_q <= bus_wdata[8:0];
          RI_LEN:    len_q    <= bus_wdata;
          RI_COL:    col_q    <= bus_wdata[15:0];
          RI_ROW:    row_q    <= bus_wdata[23:0];
          RI_SRST:   srst_q   <= bus_wdata[0];
          default: ;
        endcase
      end
      if (srst_q)        done_q <= 1'b0;
      else if (seq_done) done_q <= 1'b1;
      else if (w1c)      done_q <= 1'b0;
      rd_q      <= reg_rd;
      sel_buf_q <= win_buf;
    end
  end

  assign bus_rdata = sel_buf_q ? {24'd0, mem_q} : rd_q;

  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (w1c && !seq_done && !srst_q) |=> !done_q);  // R7
  AST_W0_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (done_q && !w1c && !srst_q) |=> done_q);  // R7
endmodule

// File: rtl/nfc_seq.sv
module nfc_seq
  import nfc_pkg::*;
#(
  parameter int CYC_LO = 2,
  parameter int CYC_HI = 2,
  parameter int TWB    = 8,
  parameter int BUF_AW = 5,
  localparam int CYC_TOT = CYC_LO + CYC_HI,
  localparam int CW = $clog2(CYC_TOT + 1),
  localparam int WW = $clog2(TWB + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              srst,
  input  logic              go,
  input  logic [7:0]        op_cmd,
  input  logic              op_apres,
  input  logic [2:0]        op_ncode,
  input  logic              op_rd,
  input  logic              op_wr,
  input  logic              op_ce,
  input  logic [8:0]        follow,
  input  logic [31:0]       len,
  input  logic [15:0]       col,
  input  logic [23:0]       row,
  input  logic              rb,
  input  logic [7:0]        dq_i,
  input  logic [7:0]        mem_q,
  output logic              busy,
  output logic              done_p,
  output logic              rb_s,
  output logic [1:0]        ce_n,
  output logic              cle,
  output logic              ale,
  output logic              we_n,
  output logic              re_n,
  output logic              dq_oe,
  output logic [7:0]        dq_o,
  output logic              buf_we,
  output logic [BUF_AW-1:0] buf_idx,
  output logic [7:0]        buf_wd
);
  seq_state_t  st, after_cmd1, after_addr, after_data;
  logic [CW-1:0] ccnt;
  logic [WW-1:0] wcnt;
  logic [31:0] bcnt;
  logic [7:0]  cmd1_q, cmd2_q;
  logic        cmd2_en_q, rd_q, wr_q, ce_q;
  logic [3:0]  nadr_q;
  logic [31:0] len_q;
  logic [63:0] adr_q;
  logic        rb_m;
  logic        cyc_end, strobe, wr_act, has_data;

  assign cyc_end  = (ccnt == CW'(CYC_TOT - 1));
  assign strobe   = (ccnt < CW'(CYC_LO));
  assign has_data = (rd_q || wr_q) && (len_q != 32'd0);
  assign busy     = (st != S_IDLE);

  assign after_data = cmd2_en_q ? S_CMD2 : S_TWB;
  assign after_addr = has_data ? S_DATA : after_data;
  assign after_cmd1 = (nadr_q != 4'd0) ? S_ADDR : after_addr;

  always_ff @(posedge clk) begin
    if (rst) begin
      rb_m <= 1'b0;
      rb_s <= 1'b0;
    end else begin
      rb_m <= rb;
      rb_s <= rb_m;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd1_q <= '0; cmd2_q <= '0; cmd2_en_q <= 1'b0;
      rd_q <= 1'b0; wr_q <= 1'b0; ce_q <= 1'b0;
      nadr_q <= '0; len_q <= '0; adr_q <= '0;
    end else if (go && st == S_IDLE && !srst) begin
      cmd1_q    <= op_cmd;
      cmd2_q    <= follow[7:0];
      cmd2_en_q <= follow[FOL_EN];
      rd_q      <= op_rd;
      wr_q      <= op_wr;
      ce_q      <= op_ce;
      nadr_q    <= op_apres ? ({1'b0, op_ncode} + 4'd1) : 4'd0;
      len_q     <= len;
      adr_q     <= {24'd0, row, col};
    end
  end

  always_ff @(posedge clk) begin
    if (rst || srst) begin
      st     <= S_IDLE;
      ccnt   <= '0;
      bcnt   <= '0;
      wcnt   <= '0;
      done_p <= 1'b0;
    end else begin
      done_p <= 1'b0;
      if (st != S_TWB) wcnt <= '0;
      case (st)
        S_IDLE: begin
          ccnt <= '0;
          bcnt <= '0;
          if (go) st <= S_CMD1;
        end
        S_CMD1: begin
          if (cyc_end) begin
            ccnt <= '0;
            st   <= after_cmd1;
          end else ccnt <= ccnt + 1'b1;
        end
        S_ADDR: begin
          if (cyc_end) begin
            ccnt <= '0;
            if (bcnt == 32'(nadr_q) - 32'd1) begin
              bcnt <= '0;
              st   <= after_addr;
            end else bcnt <= bcnt + 32'd1;
          end else ccnt <= ccnt + 1'b1;
        end
        S_DATA: begin
          if (cyc_end) begin
            ccnt <= '0;
            if (bcnt == len_q - 32'd1) begin
              bcnt <= '0;
              st   <= after_data;
            end else bcnt <= bcnt + 32'd1;
          end else ccnt <= ccnt + 1'b1;
        end
        S_CMD2: begin
          if (cyc_end) begin
            ccnt <= '0;
            st   <= S_TWB;
          end else ccnt <= ccnt + 1'b1;
        end
        S_TWB: begin
          if (wcnt == WW'(TWB - 1)) st <= S_WAITRDY;
          else wcnt <= wcnt + 1'b1;
        end
        S_WAITRDY: begin
          if (rb_s) begin
            done_p <= 1'b1;
            st     <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // Pin values, registered once more at the top level
  assign wr_act = (st == S_CMD1) || (st == S_ADDR) || (st == S_CMD2) ||
                  ((st == S_DATA) && !rd_q);
  assign we_n   = !(wr_act && strobe);
  assign re_n   = !((st == S_DATA) && rd_q && strobe);
  assign cle    = (st == S_CMD1) || (st == S_CMD2);
  assign ale    = (st == S_ADDR);
  assign dq_oe  = wr_act;
  assign ce_n   = busy ? (ce_q ? 2'b01 : 2'b10) : 2'b11;

  always_comb begin
    case (st)
      S_CMD1:  dq_o = cmd1_q;
      S_CMD2:  dq_o = cmd2_q;
      S_ADDR:  dq_o = adr_q[{bcnt[2:0], 3'b000} +: 8];
      S_DATA:  dq_o = mem_q;
      default: dq_o = 8'h00;
    endcase
  end

  // Read byte is captured on the first high clock, while the pin is still low
  assign buf_we  = (st == S_DATA) && rd_q && (ccnt == CW'(CYC_LO));
  assign buf_idx = bcnt[BUF_AW-1:0];
  assign buf_wd  = dq_i;

  AST_IGNORE_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    (go && busy) |=> ($stable(cmd1_q) && $stable(len_q) && $stable(nadr_q)));  // R9
  AST_TWB_ELAPSED: assert property (@(posedge clk) disable iff (rst || srst)
    (st == S_TWB && $past(st) != S_TWB) |=> (st == S_TWB || wcnt == WW'(TWB - 1)));  // R6
  AST_DONE_AFTER_READY: assert property (@(posedge clk) disable iff (rst)
    done_p |-> ($past(st) == S_WAITRDY && $past(rb_s)));  // R6
  AST_CAPTURE_ONLY_READ: assert property (@(posedge clk) disable iff (rst)
    buf_we |-> (rd_q && $past(!re_n)));  // R4
endmodule

// File: rtl/nfc_cmd_engine.sv
module nfc_cmd_engine
  import nfc_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int BUF_DEPTH = 32,
  parameter int CYC_LO    = 2,
  parameter int CYC_HI    = 2,
  parameter int TWB       = 8,
  localparam int BUF_AW = $clog2(BUF_DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_we,
  output logic [31:0]       bus_rdata,
  output logic              irq,
  output logic [1:0]        nf_ce_n,
  output logic              nf_cle,
  output logic              nf_ale,
  output logic              nf_we_n,
  output logic              nf_re_n,
  output logic [7:0]        nf_dq_o,
  output logic              nf_dq_oe,
  input  logic [7:0]        nf_dq_i,
  input  logic              nf_rb
);
  logic [31:0] op_q, len_q;
  logic [8:0]  follow_q;
  logic [15:0] col_q;
  logic [23:0] row_q;
  logic        go_q, srst_q, done_q;
  logic        seq_busy, seq_done, rb_s;
  logic [1:0]  s_ce_n;
  logic        s_cle, s_ale, s_we_n, s_re_n, s_oe;
  logic [7:0]  s_dq;
  logic        s_bwe, b_we;
  logic [BUF_AW-1:0] s_bidx, b_idx, m_wa, m_ra;
  logic [7:0]  s_bwd, b_wd, m_wd, mem_q;

  nfc_regs #(.ADDR_W(ADDR_W), .BUF_AW(BUF_AW)) u_regs (
    .clk, .rst, .bus_addr, .bus_wdata, .bus_we,
    .seq_busy, .seq_done, .rb_s, .mem_q,
    .op_q, .follow_q, .len_q, .col_q, .row_q,
    .go_q, .srst_q, .done_q, .bus_rdata,
    .bb_we(b_we), .bb_idx(b_idx), .bb_wd(b_wd)
  );

  nfc_seq #(.CYC_LO(CYC_LO), .CYC_HI(CYC_HI), .TWB(TWB), .BUF_AW(BUF_AW)) u_seq (
    .clk, .rst, .srst(srst_q), .go(go_q),
    .op_cmd(op_q[7:0]), .op_apres(op_q[OP_APRES]), .op_ncode(op_q[29:27]),
    .op_rd(op_q[OP_RD]), .op_wr(op_q[OP_WR]), .op_ce(op_q[OP_CESEL]),
    .follow(follow_q), .len(len_q), .col(col_q), .row(row_q),
    .rb(nf_rb), .dq_i(nf_dq_i), .mem_q,
    .busy(seq_busy), .done_p(seq_done), .rb_s,
    .ce_n(s_ce_n), .cle(s_cle), .ale(s_ale), .we_n(s_we_n), .re_n(s_re_n),
    .dq_oe(s_oe), .dq_o(s_dq),
    .buf_we(s_bwe), .buf_idx(s_bidx), .buf_wd(s_bwd)
  );

  assign m_wa = s_bwe ? s_bidx : b_idx;
  assign m_wd = s_bwe ? s_bwd : b_wd;
  assign m_ra = seq_busy ? s_bidx : bus_addr[BUF_AW-1:0];

  nfc_buf #(.DEPTH(BUF_DEPTH)) u_buf (
    .clk, .we(s_bwe || b_we), .wa(m_wa), .wd(m_wd), .ra(m_ra), .q(mem_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      nf_ce_n  <= 2'b11;
      nf_cle   <= 1'b0;
      nf_ale   <= 1'b0;
      nf_we_n  <= 1'b1;
      nf_re_n  <= 1'b1;
      nf_dq_o  <= '0;
      nf_dq_oe <= 1'b0;
    end else begin
      nf_ce_n  <= s_ce_n;
      nf_cle   <= s_cle;
      nf_ale   <= s_ale;
      nf_we_n  <= s_we_n;
      nf_re_n  <= s_re_n;
      nf_dq_o  <= s_dq;
      nf_dq_oe <= s_oe;
    end
  end

  assign irq = done_q;

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
    !(!nf_we_n && !nf_re_n));  // R3
  AST_IDLE_CE_HIGH: assert property (@(posedge clk) disable iff (rst)
    !$past(seq_busy) |-> (nf_ce_n == 2'b11));  // R1
  AST_SRST_HOLDS_IDLE: assert property (@(posedge clk) disable iff (rst)
    srst_q |=> (!seq_busy && !done_q));  // R10
  AST_CE_ONE_HOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~nf_ce_n));  // R1
endmodule

// File: tb/sim_nfc_cmd_engine.sv
module sim_nfc_cmd_engine;
  localparam int DEPTH = 32;
  localparam int TWB   = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_rdata;
  logic        irq;
  logic [1:0]  nf_ce_n;
  logic        nf_cle, nf_ale, nf_we_n, nf_re_n, nf_dq_oe;
  logic [7:0]  nf_dq_o, nf_dq_i;
  logic        nf_rb;

  int nchk = 0, nerr = 0;

  always #10 clk = ~clk;

  nfc_cmd_engine #(.BUF_DEPTH(DEPTH), .TWB(TWB)) u0 (
    .clk, .rst, .bus_addr, .bus_wdata, .bus_we, .bus_rdata, .irq,
    .nf_ce_n, .nf_cle, .nf_ale, .nf_we_n, .nf_re_n,
    .nf_dq_o, .nf_dq_oe, .nf_dq_i, .nf_rb
  );

  // Flash model and pin logger, sampled on the falling clock edge
  logic [7:0] cmd_log [16];
  logic [7:0] adr_log [16];
  logic [7:0] dat_log [64];
  logic [7:0] rd_src  [64];
  logic [7:0] shadow  [DEPTH];
  int ncmd, nadr, ndat, rd_ptr, busy_cnt, busy_len, cyc, last_we_t, irq_t;
  logic [1:0] ce_seen;
  logic prev_we = 1'b1, prev_re = 1'b1, prev_irq = 1'b0, rb_hold = 1'b0;

  assign nf_rb   = !rb_hold && (busy_cnt == 0);
  assign nf_dq_i = rd_src[rd_ptr[5:0]];

  initial begin
    ncmd = 0; nadr = 0; ndat = 0; rd_ptr = 0; busy_cnt = 0; busy_len = 6;
    cyc = 0; last_we_t = 0; irq_t = 0; ce_seen = 2'b00;
  end

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (busy_cnt > 0) busy_cnt = busy_cnt - 1;
    if (nf_ce_n != 2'b11) ce_seen = ce_seen | ~nf_ce_n;
    if (nf_we_n && !prev_we) begin
      last_we_t = cyc;
      if (nf_cle) begin
        if (ncmd < 16) cmd_log[ncmd] = nf_dq_o;
        ncmd = ncmd + 1;
        busy_cnt = busy_len;
      end else if (nf_ale) begin
        if (nadr < 16) adr_log[nadr] = nf_dq_o;
        nadr = nadr + 1;
      end else begin
        if (ndat < 64) dat_log[ndat] = nf_dq_o;
        ndat = ndat + 1;
      end
    end
    if (nf_re_n && !prev_re) rd_ptr = rd_ptr + 1;
    if (irq && !prev_irq) irq_t = cyc;
    prev_we = nf_we_n; prev_re = nf_re_n; prev_irq = irq;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic bus_rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  function automatic logic [7:0] adr_byte(input logic [15:0] c, input logic [23:0] r, input int k);
    logic [63:0] v;
    v = {24'd0, r, c};
    return v[k*8 +: 8];
  endfunction

  task automatic fill_buf();
    for (int i = 0; i < DEPTH; i++) begin
      shadow[i] = 8'($urandom);
      bus_wr(6'(32 + i), {24'd0, shadow[i]});
    end
  endtask

  task automatic wait_done(output bit ok);
    ok = 0;
    for (int t = 0; t < 5000; t++) begin
      @(negedge clk);
      if (irq) begin ok = 1; break; end
    end
  endtask

  task automatic clear_logs();
    ncmd = 0; nadr = 0; ndat = 0; rd_ptr = 0; ce_seen = 2'b00;
    for (int i = 0; i < 64; i++) rd_src[i] = 8'($urandom);
  endtask

  // Run one operation and check every effect against the requirements
  task automatic run_op(input logic [31:0] ctl, input logic [8:0] fol,
                        input logic [31:0] ln, input logic [15:0] c, input logic [23:0] r);
    bit ok, bad;
    int exp_n, exp_cmd, exp_dat;
    logic [31:0] d;
    bus_wr(6'd3, {16'd0, c});
    bus_wr(6'd4, {8'd0, r});
    bus_wr(6'd2, ln);
    bus_wr(6'd1, {23'd0, fol});
    clear_logs();
    bus_wr(6'd0, ctl | 32'h8000_0000);
    bus_rd(6'd5, d);
    chk(d[31] == 1'b1, "R8 busy during op", d[31], 1);
    wait_done(ok);
    chk(ok, "R6 done flag", irq, 1);
    exp_cmd = fol[8] ? 2 : 1;
    chk(ncmd == exp_cmd && cmd_log[0] == ctl[7:0], "R1 first command", {ncmd, cmd_log[0]}, {exp_cmd, ctl[7:0]});
    if (fol[8]) chk(cmd_log[1] == fol[7:0], "R5 second command", cmd_log[1], fol[7:0]);
    chk(ce_seen == (ctl[19] ? 2'b10 : 2'b01), "R1 chip enable", ce_seen, ctl[19] ? 2 : 1);
    exp_n = ctl[30] ? int'(ctl[29:27]) + 1 : 0;
    bad = (nadr != exp_n);
    for (int k = 0; k < exp_n && k < 16; k++) if (adr_log[k] != adr_byte(c, r, k)) bad = 1;
    chk(!bad, "R2 address cycles", nadr, exp_n);
    exp_dat = (ctl[25] && !ctl[26]) ? int'(ln) : 0;
    bad = (ndat != exp_dat);
    for (int k = 0; k < exp_dat && k < 64; k++) if (dat_log[k] != shadow[k % DEPTH]) bad = 1;
    chk(!bad, "R3 write data", ndat, exp_dat);
    if (ctl[26]) begin
      for (int k = 0; k < int'(ln); k++) shadow[k % DEPTH] = rd_src[k];
      chk(rd_ptr == int'(ln), "R4 read strobes", rd_ptr, ln);
      bad = 0;
      for (int k = 0; k < DEPTH; k++) begin
        bus_rd(6'(32 + k), d);
        if (d[7:0] != shadow[k]) bad = 1;
      end
      chk(!bad, "R4 read data in buffer", bad, 0);
    end
    bus_rd(6'd6, d);
    chk(d[31] == 1'b1, "R6 irq register bit", d[31], 1);
    bus_wr(6'd6, 32'h8000_0000);
    @(negedge clk);
    chk(irq == 1'b0, "R7 write-1 clear", irq, 0);
  endtask

  initial begin
    logic [31:0] d;
    logic [31:0] ctl;
    bit ok;
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    // R11 reset state
    chk(nf_ce_n == 2'b11 && nf_we_n && nf_re_n && !nf_cle && !nf_ale && !nf_dq_oe,
        "R11 pins after reset", {nf_ce_n, nf_we_n, nf_re_n, nf_cle, nf_ale, nf_dq_oe}, 7'b1111000);
    bus_rd(6'd5, d);
    chk(d[31:30] == 2'b01, "R11 R8 status after reset", d[31:30], 2'b01);
    bus_rd(6'd6, d);
    chk(d[31] == 1'b0 && !irq, "R11 irq after reset", d[31], 0);
    // R8 ready bit follows the line
    rb_hold = 1'b1;
    repeat (4) @(negedge clk);
    bus_rd(6'd5, d);
    chk(d[30] == 1'b0, "R8 ready low", d[30], 0);
    rb_hold = 1'b0;
    repeat (4) @(negedge clk);
    bus_rd(6'd5, d);
    chk(d[30] == 1'b1, "R8 ready high", d[30], 1);

    fill_buf();
    // Directed: program with confirm, five address bytes, write phase, CE1
    run_op(32'h4008_0080 | (32'd4 << 27) | (32'd1 << 25), 9'h110, 32'd12, 16'hA1B2, 24'hC3D4E5);
    // Directed: read with read-start, read beats write when both set, wraps buffer
    run_op(32'h4000_0000 | (32'd4 << 27) | (32'd3 << 25), 9'h130, 32'd40, 16'h0102, 24'h030405);
    // Directed: eight address cycles, upper bytes zero, no data, no second command
    run_op(32'h4000_0070 | (32'd7 << 27), 9'h000, 32'd5, 16'hFFEE, 24'hDDCCBB);
    // Directed: no address phase, read flag with zero length
    run_op(32'h0400_0090, 9'h000, 32'd0, 16'h0, 24'h0);

    // R6 settle delay with ready already high
    busy_len = 0;
    run_op(32'h4000_00FF, 9'h000, 32'd0, 16'h0, 24'h0);
    chk(irq_t - last_we_t >= TWB, "R6 wait after last cycle", irq_t - last_we_t, TWB);
    busy_len = 6;

    // R7 write of zero keeps the flag
    bus_wr(6'd0, 32'h8000_0011);
    wait_done(ok);
    bus_wr(6'd6, 32'h0000_0000);
    bus_rd(6'd6, d);
    chk(d[31] == 1'b1 && irq, "R7 write zero keeps flag", d[31], 1);
    bus_wr(6'd6, 32'h8000_0000);

    // R9 start while busy is ignored
    bus_wr(6'd1, 9'h110);
    bus_wr(6'd2, 32'd8);
    clear_logs();
    bus_wr(6'd0, 32'h8200_0080);
    repeat (10) @(negedge clk);
    bus_wr(6'd0, 32'h8000_0055);
    wait_done(ok);
    repeat (80) @(negedge clk);
    chk(ncmd == 2 && cmd_log[0] == 8'h80 && cmd_log[1] == 8'h10, "R9 busy start ignored", ncmd, 2);
    bus_rd(6'd5, d);
    chk(d[31] == 1'b0, "R9 idle after", d[31], 0);
    bus_wr(6'd6, 32'h8000_0000);

    // R10 soft reset aborts a running op and clears done
    bus_wr(6'd0, 32'h8000_0022);
    wait_done(ok);
    bus_wr(6'd2, 32'd30);
    bus_wr(6'd0, 32'h8200_0080);
    repeat (20) @(negedge clk);
    bus_wr(6'd7, 32'd1);
    repeat (2) @(negedge clk);
    chk(nf_ce_n == 2'b11 && !irq, "R10 idle under soft reset", {nf_ce_n, irq}, 3'b110);
    bus_rd(6'd5, d);
    chk(d[31] == 1'b0, "R10 not busy", d[31], 0);
    bus_wr(6'd0, 32'h8000_0033);
    repeat (10) @(negedge clk);
    chk(nf_ce_n == 2'b11, "R10 start held off", nf_ce_n, 3);
    bus_wr(6'd7, 32'd0);
    run_op(32'h4000_0060 | (32'd2 << 27), 9'h1D0, 32'd0, 16'h1234, 24'h56);

    // Random operations
    for (int n = 0; n < 24; n++) begin
      if (n % 6 == 0) fill_buf();
      ctl = {1'b0, 1'($urandom), 3'($urandom), 2'($urandom), 5'd0, 1'($urandom), 11'd0, 8'($urandom)};
      run_op(ctl, 9'($urandom), 32'($urandom_range(0, 40)), 16'($urandom), 24'($urandom));
    end

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    #(20 * 190000);
    nerr++;
    nchk++;
    $display("FAIL watchdog R6: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule